// File: doc/BRIEF.md
# Prescaled PWM Channel Generator

This block produces one pulse-width-modulated output. A two-stage prescaler (an 8-bit mantissa and a 4-bit power-of-two exponent) divides the input clock into time quanta. An 8-bit period counter advances once per quantum and wraps after a programmable terminal count. A rise point and a fall point, both compared against the counter, shape the waveform. Three control bits gate and shape the pin:
- a count enable starts the counters and resets them when cleared;
- an output enable forces the pin to its idle level;
- a polarity bit inverts the pin at once.

Period and compare-point writes go to a shadow bank. The live compare values take them on at the next period boundary. A bypass bit makes such writes live immediately.

The channel is controlled by a two-state machine:
- `ST_IDLE`: counters held at zero; the live values follow the shadow values.
- `ST_RUN`: counting.

Its transitions are:
- `T_START` (`ST_IDLE` to `ST_RUN`), taken when the count enable is set.
- `T_STOP` (`ST_RUN` to `ST_IDLE`), taken when the count enable is cleared.
- `T_HOLD_IDLE` and `T_HOLD_RUN` keep the current state.

Software writes one field per cycle with `wr_en`, `wr_sel` and `wr_data`. The field codes are:

| `wr_sel` | Field |
|---|---|
| 0 | mantissa |
| 1 | exponent, in bits 3:0 |
| 2 | period terminal count |
| 3 | rise point |
| 4 | fall point |
| 5 | control |

Control bits: bit0 count enable, bit1 output enable, bit2 polarity invert, bit3 sync bypass.

Top module: `pwm_quantum_channel`

## Requirements
- R1: One quantum lasts (mantissa+1) << exponent input clocks. The period counter advances once per quantum.
- R2: A period lasts (terminal+1) quanta. The counter wraps from the terminal count to 0, and that wrap is the period boundary.
- R3: The output is active while the count is at or past the rise point and before the fall point. When rise > fall, the active span wraps through 0.
- R4: When rise equals fall, the output is active for the whole period.
- R5: While count enable (control bit0) is 0, the counter is held at 0 and the pin is at its idle level from the cycle after the write. Values written while it is 0 apply once it is set.
- R6: While output enable (control bit1) is 0, the pin is at its idle level whatever the waveform.
- R7: Polarity invert (control bit2) flips the pin in the cycle after its write. The idle level equals this bit.
- R8: With sync bypass (control bit3) at 0, period and point writes made during a running period take effect only at the next period boundary.
- R9: With sync bypass at 1, period and point writes take effect in the cycle after the write.
- R10: After reset all fields and control bits are 0 and the pin is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | input clock |
| rst_n | input | 1 | asynchronous reset, active low |
| wr_en | input | 1 | field write strobe |
| wr_sel | input | 3 | field code (see table) |
| wr_data | input | 8 | write data |
| pwm_pin | output | 1 | PWM output pin |

## Verification
The hardest situation to reach is a write that lands in the middle of a running period and must stay invisible until the wrap. The bench waits for the pin's rising edge, which marks count 0 when the rise point is 0. In that same cycle it writes a new fall point. It then counts active samples over exactly one period and over the next, once with sync on and once with bypass. Stop and restart cases are reached by toggling the count enable with pending writes.

// File: rtl/pwm_chan_pkg.sv
package pwm_chan_pkg;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } chan_state_e;

    typedef enum logic [2:0] {
        SEL_MANT   = 3'd0,
        SEL_EXP    = 3'd1,
        SEL_PERIOD = 3'd2,
        SEL_RISE   = 3'd3,
        SEL_FALL   = 3'd4,
        SEL_CTRL   = 3'd5
    } field_sel_e;

    typedef struct packed {
        logic sync_byp;
        logic pol_inv;
        logic out_en;
        logic cnt_en;
    } chan_ctrl_t;

endpackage

// File: rtl/pwm_quantum_prescaler.sv
module pwm_quantum_prescaler #(
    parameter int MANT_W = 8,
    parameter int EXP_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic [MANT_W-1:0] mant,
    input  logic [EXP_W-1:0]  expo,
    output logic              tick
);
    localparam int PRE_W = MANT_W + 1 + (2 ** EXP_W) - 1;

    logic [PRE_W-1:0] limit;
    logic [PRE_W-1:0] pre_cnt;

    always_comb begin
        limit = (PRE_W'(mant) + PRE_W'(1)) << expo;
        tick  = run && (pre_cnt >= limit - PRE_W'(1));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pre_cnt <= '0;
        end else if (!run || tick) begin
            pre_cnt <= '0;
        end else begin
            pre_cnt <= pre_cnt + PRE_W'(1);
        end
    end

    a_r1_tick_restarts: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> (pre_cnt == '0));
    a_r5_prescaler_held: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> (pre_cnt == '0));
endmodule

// File: rtl/pwm_period_counter.sv
module pwm_period_counter #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             tick,
    input  logic [CNT_W-1:0] terminal,
    output logic [CNT_W-1:0] count,
    output logic             boundary
);
    always_comb begin
        boundary = tick && (count >= terminal);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count <= '0;
        end else if (!run || boundary) begin
            count <= '0;
        end else if (tick) begin
            count <= count + CNT_W'(1);
        end
    end

    a_r2_wrap_to_zero: assert property (@(posedge clk) disable iff (!rst_n)
        boundary |=> (count == '0));
    a_r5_counter_held: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> (count == '0));
    a_r1_still_between_ticks: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !tick) |=> $stable(count));
endmodule

// File: rtl/pwm_shadow_bank.sv
module pwm_shadow_bank #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             boundary,
    input  logic             bypass,
    input  logic             wr_period,
    input  logic             wr_rise,
    input  logic             wr_fall,
    input  logic [CNT_W-1:0] wr_data,
    output logic [CNT_W-1:0] live_period,
    output logic [CNT_W-1:0] live_rise,
    output logic [CNT_W-1:0] live_fall
);
    logic [CNT_W-1:0] sh_period, sh_rise, sh_fall;
    logic [CNT_W-1:0] nx_period, nx_rise, nx_fall;
    logic             load;

    always_comb begin
        nx_period = wr_period ? wr_data : sh_period;
        nx_rise   = wr_rise   ? wr_data : sh_rise;
        nx_fall   = wr_fall   ? wr_data : sh_fall;
        load      = !run || boundary || bypass;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh_period   <= '0;
            sh_rise     <= '0;
            sh_fall     <= '0;
            live_period <= '0;
            live_rise   <= '0;
            live_fall   <= '0;
        end else begin
            sh_period <= nx_period;
            sh_rise   <= nx_rise;
            sh_fall   <= nx_fall;
            if (load) begin
                live_period <= nx_period;
                live_rise   <= nx_rise;
                live_fall   <= nx_fall;
            end
        end
    end

    a_r8_live_held_mid_period: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !bypass && !boundary) |=>
            ($stable(live_period) && $stable(live_rise) && $stable(live_fall)));
    a_r9_bypass_follows: assert property (@(posedge clk) disable iff (!rst_n)
        (bypass && wr_fall) |=> (live_fall == $past(wr_data)));
endmodule

// File: rtl/pwm_quantum_channel.sv
module pwm_quantum_channel
    import pwm_chan_pkg::*;
#(
    parameter int MANT_W = 8,
    parameter int EXP_W  = 4,
    parameter int CNT_W  = 8
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_en,
    input  logic [2:0] wr_sel,
    input  logic [7:0] wr_data,
    output logic       pwm_pin
);
    localparam int CTRL_W = $bits(chan_ctrl_t);

    chan_state_e      state_q, state_d;
    chan_ctrl_t       ctrl_q;
    logic [MANT_W-1:0] mant_q;
    logic [EXP_W-1:0]  expo_q;
    logic             run, tick, boundary, wave_on;
    logic [CNT_W-1:0] count, live_period, live_rise, live_fall;
    logic             wr_period, wr_rise, wr_fall;

    always_comb begin
        wr_period = wr_en && (wr_sel == SEL_PERIOD);
        wr_rise   = wr_en && (wr_sel == SEL_RISE);
        wr_fall   = wr_en && (wr_sel == SEL_FALL);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q <= '0;
            mant_q <= '0;
            expo_q <= '0;
        end else if (wr_en) begin
            if (wr_sel == SEL_CTRL) ctrl_q <= chan_ctrl_t'(wr_data[CTRL_W-1:0]);
            if (wr_sel == SEL_MANT) mant_q <= wr_data[MANT_W-1:0];
            if (wr_sel == SEL_EXP)  expo_q <= wr_data[EXP_W-1:0];
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Next state: T_START, T_STOP, T_HOLD_IDLE, T_HOLD_RUN
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (ctrl_q.cnt_en)  state_d = ST_RUN;
            ST_RUN:  if (!ctrl_q.cnt_en) state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // Outputs of the state machine
    always_comb begin
        run = (state_q == ST_RUN);
    end

    pwm_quantum_prescaler #(.MANT_W(MANT_W), .EXP_W(EXP_W)) u_presc (
        .clk(clk), .rst_n(rst_n), .run(run),
        .mant(mant_q), .expo(expo_q), .tick(tick)
    );

    pwm_period_counter #(.CNT_W(CNT_W)) u_ctr (
        .clk(clk), .rst_n(rst_n), .run(run), .tick(tick),
        .terminal(live_period), .count(count), .boundary(boundary)
    );

    pwm_shadow_bank #(.CNT_W(CNT_W)) u_shadow (
        .clk(clk), .rst_n(rst_n), .run(run), .boundary(boundary),
        .bypass(ctrl_q.sync_byp), .wr_period(wr_period), .wr_rise(wr_rise),
        .wr_fall(wr_fall), .wr_data(wr_data[CNT_W-1:0]),
        .live_period(live_period), .live_rise(live_rise), .live_fall(live_fall)
    );

    always_comb begin
        if (live_rise == live_fall)
            wave_on = 1'b1;
        else if (live_rise < live_fall)
            wave_on = (count >= live_rise) && (count < live_fall);
        else
            wave_on = (count >= live_rise) || (count < live_fall);
        pwm_pin = ctrl_q.pol_inv ^
                  (run && ctrl_q.cnt_en && ctrl_q.out_en && wave_on);
    end

    a_r5_stopped_idle_level: assert property (@(posedge clk) disable iff (!rst_n)
        !ctrl_q.cnt_en |-> (pwm_pin == ctrl_q.pol_inv));
    a_r6_gated_idle_level: assert property (@(posedge clk) disable iff (!rst_n)
        !ctrl_q.out_en |-> (pwm_pin == ctrl_q.pol_inv));
    a_r4_full_duty: assert property (@(posedge clk) disable iff (!rst_n)
        (run && ctrl_q.cnt_en && ctrl_q.out_en && live_rise == live_fall)
            |-> (pwm_pin == !ctrl_q.pol_inv));
    a_r2_count_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !ctrl_q.sync_byp && $stable(live_period)) |-> (count <= live_period));
endmodule

// File: tb/pwm_quantum_channel_tb.sv
module pwm_quantum_channel_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [2:0] wr_sel = '0;
    logic [7:0] wr_data = '0;
    logic       pwm_pin;
    int         n_checks = 0;
    int         n_errors = 0;
    bit         done = 1'b0;

    always #5 clk = ~clk;

    pwm_quantum_channel u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en),
        .wr_sel(wr_sel), .wr_data(wr_data), .pwm_pin(pwm_pin)
    );

    task automatic check(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] sel, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = sel; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic count_high(input int n, output int hi);
        hi = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (pwm_pin) hi++;
        end
    endtask

    task automatic count_rises(input int n, output int rises);
        logic prev;
        rises = 0;
        @(negedge clk);
        prev = pwm_pin;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (!prev && pwm_pin) rises++;
            prev = pwm_pin;
        end
    endtask

    // stop, load all fields, start with count and output enabled
    task automatic setup(input int m, input int e, input int p, input int r,
                         input int f, input logic [7:0] extra);
        wr(3'd5, 8'h02);
        wr(3'd0, 8'(m)); wr(3'd1, 8'(e)); wr(3'd2, 8'(p));
        wr(3'd3, 8'(r)); wr(3'd4, 8'(f));
        wr(3'd5, 8'h03 | extra);
        repeat (40) @(negedge clk);
    endtask

    task automatic t_reset;
        @(negedge clk);
        check("R10 pin after reset", pwm_pin, 0);
    endtask

    task automatic t_prescale;
        int hi, rs;
        setup(1, 1, 3, 0, 1, 8'h00);       // quantum 4, period 16
        count_high(64, hi);
        check("R1 duty with quantum 4", hi, 16);
        count_rises(64, rs);
        check("R2 periods of 16 in 64 cycles", rs, 4);
        setup(2, 0, 4, 0, 2, 8'h00);       // quantum 3, period 15
        count_high(60, hi);
        check("R1 duty with quantum 3", hi, 24);
        count_rises(60, rs);
        check("R2 periods of 15 in 60 cycles", rs, 4);
    endtask

    task automatic t_points;
        int hi;
        setup(0, 0, 9, 2, 5, 8'h00);
        count_high(50, hi);
        check("R3 rise<fall span", hi, 15);
        setup(0, 0, 9, 7, 2, 8'h00);
        count_high(50, hi);
        check("R3 wrapped span", hi, 25);
        setup(0, 0, 9, 4, 4, 8'h00);
        count_high(50, hi);
        check("R4 equal points full duty", hi, 50);
    endtask

    task automatic t_enable;
        int hi;
        setup(0, 0, 9, 4, 4, 8'h00);
        wr(3'd5, 8'h02);                   // clear count enable
        check("R5 pin idle next cycle", pwm_pin, 0);
        count_high(10, hi);
        check("R5 pin stays idle", hi, 0);
        wr(3'd3, 8'd0); wr(3'd4, 8'd3);
        wr(3'd5, 8'h03);
        repeat (20) @(negedge clk);
        count_high(50, hi);
        check("R5 values written while stopped apply", hi, 15);
    endtask

    task automatic t_outen;
        int hi;
        setup(0, 0, 9, 4, 4, 8'h00);
        wr(3'd5, 8'h01);
        count_high(20, hi);
        check("R6 output disabled idle", hi, 0);
        wr(3'd5, 8'h03);
        check("R6 output re-enabled", pwm_pin, 1);
    endtask

    task automatic t_invert;
        setup(0, 0, 9, 4, 4, 8'h00);
        wr(3'd5, 8'h07);
        check("R7 invert next cycle", pwm_pin, 0);
        wr(3'd5, 8'h05);
        check("R7 idle level inverted (output off)", pwm_pin, 1);
        wr(3'd5, 8'h06);
        check("R7 idle level inverted (stopped)", pwm_pin, 1);
    endtask

    task automatic sync_run(input logic [7:0] extra, output int first, output int second);
        logic prev;
        setup(0, 0, 99, 0, 10, extra);
        @(negedge clk);
        prev = pwm_pin;
        forever begin
            @(negedge clk);
            if (!prev && pwm_pin) break;
            prev = pwm_pin;
        end
        wr_en = 1'b1; wr_sel = 3'd4; wr_data = 8'd50;
        first = 1;
        for (int i = 1; i < 100; i++) begin
            @(negedge clk);
            if (i == 1) wr_en = 1'b0;
            if (pwm_pin) first++;
        end
        count_high(100, second);
    endtask

    task automatic t_sync;
        int a, b;
        sync_run(8'h00, a, b);
        check("R8 current period keeps old fall", a, 10);
        check("R8 next period uses new fall", b, 50);
        sync_run(8'h08, a, b);
        check("R9 bypass applies at once", a, 50);
    endtask

    initial begin
        fork
            begin
                repeat (3) @(negedge clk);
                rst_n = 1'b1;
                t_reset();
                t_prescale();
                t_points();
                t_enable();
                t_outen();
                t_invert();
                t_sync();
                done = 1'b1;
            end
            begin
                repeat (100000) @(posedge clk);
                if (!done) begin
                    n_checks++;
                    n_errors++;
                    $display("FAIL watchdog: actual=timeout expected=completion");
                end
            end
        join_any
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end
endmodule